// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver Channel

This block passes a parallel word in both directions between a push-pull side (side A) and an open-drain, wired-AND side (side B). Each direction owns one storage element and four controls. A level enable makes the storage follow its input. An edge input stores a new word on a rising edge. An active-low gate lets that edge through or blocks it. An active-low output enable connects the stored word to the far side or isolates it.

The model is fully synchronous to a fast system clock. All port controls are sampled as ordinary inputs. A rising edge on a direction's edge input is a low-to-high change between two consecutive samples. Stored words appear one system cycle after the sampling edge. Side A is driven as data plus a drive-enable flag, and its data is forced to zero while isolated. Side B is driven as a per-bit pull-low vector: a stored 0 pulls its line low and a stored 1 releases it. The B-to-A path reads the resolved line level, in which a released, unpulled line reads as 1.

Top module: `ubt_xcvr`

## Requirements
- R1: While reset is high, both stored words become 0, `b_pull` is all zero, `a_out_en` is 0 and `a_out` is 0 from the next cycle on.
- R2: When a direction's level enable is 1 in a sampling cycle, that direction's stored word becomes the input sampled in that cycle, whatever its edge input and edge gate are.
- R3: When the level enable is 0, the gate (active low) is 0, and the edge input is 1 after being 0 in the previous sample, the stored word becomes the input sampled in that cycle.
- R4: When the level enable is 0 and the edge input shows no low-to-high change, the stored word does not change.
- R5: When the level enable is 0 and the gate is 1, a low-to-high change of the edge input leaves the stored word unchanged.
- R6: After the level enable falls, the stored word is the input sampled in the last cycle with the level enable at 1.
- R7: The output enables are active low and take effect one cycle after sampling. With `ab_oe_n` = 1, `b_pull` is all zero. With `ba_oe_n` = 1, `a_out_en` and `a_out` are 0.
- R8: With the A-to-B output enabled, `b_pull[i]` is 1 exactly when bit i of the A-to-B stored word is 0.
- R9: The B-to-A path takes `b_line` as its input, so a line pulled low by any driver, including this block, is received as 0.
- R10: Controls of one direction have no effect on the other direction's stored word or outputs.
- R11: An edge input that is already 1 in the first sample after reset is not a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B level (follow) enable |
| ab_clk | input | 1 | A-to-B storage edge input |
| ab_ce_n | input | 1 | A-to-B edge gate, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A level (follow) enable |
| ba_clk | input | 1 | B-to-A storage edge input |
| ba_ce_n | input | 1 | B-to-A edge gate, active low |
| a_in | input | WIDTH | Side A word into the A-to-B path |
| a_out | output | WIDTH | Side A word out of the B-to-A path, zero when isolated |
| a_out_en | output | 1 | Side A drive enable |
| b_line | input | WIDTH | Resolved side B line levels (released reads 1) |
| b_pull | output | WIDTH | Side B pull-low request per bit |

## Verification
The properties assume that every control and data input is at a known 0 or 1 on each rising system edge. They also assume that `b_line` already reflects this block's own `b_pull` as a wired-AND with any outside drivers. The bench drives all inputs only at falling system edges. It builds `b_line` as the AND of the released lines from this block and from an outside pull vector. Edge inputs are plain levels that the bench toggles at most once per cycle, so every low-to-high change spans exactly two samples.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    typedef enum logic [1:0] {
        XFER_FOLLOW  = 2'd0,
        XFER_CAPTURE = 2'd1,
        XFER_KEEP    = 2'd2,
        XFER_BLOCKED = 2'd3
    } xfer_mode_e;

    // Priority: level enable first, then the edge gate, then the edge itself.
    function automatic xfer_mode_e pick_mode(
        input logic le,
        input logic ce_n,
        input logic edge_now,
        input logic edge_prev
    );
        xfer_mode_e m;
        if (le)
            m = XFER_FOLLOW;
        else if (ce_n)
            m = XFER_BLOCKED;
        else if (edge_now && !edge_prev)
            m = XFER_CAPTURE;
        else
            m = XFER_KEEP;
        return m;
    endfunction

endpackage

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             oe_n,
    input  logic             le,
    input  logic             edge_in,
    input  logic             ce_n,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             edge_seen;
        logic             enabled;
    } path_state_t;

    path_state_t state_d, state_q;
    xfer_mode_e  mode;

    always_comb begin
        state_d = state_q;
        mode    = pick_mode(le, ce_n, edge_in, state_q.edge_seen);
        case (mode)
            XFER_FOLLOW:  state_d.word = din;
            XFER_CAPTURE: state_d.word = din;
            default:      state_d.word = state_q.word;
        endcase
        state_d.edge_seen = edge_in;
        state_d.enabled   = ~oe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.word      <= '0;
            state_q.edge_seen <= 1'b1;
            state_q.enabled   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout  = state_q.word;
    assign drive = state_q.enabled;

endmodule

// File: rtl/ubt_od_drive.sv
module ubt_od_drive #(
    parameter int WIDTH = 18
) (
    input  logic [WIDTH-1:0] data,
    input  logic             drive,
    output logic [WIDTH-1:0] pull_low
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pull_low[i] = drive & ~data[i];
    end

endmodule

// File: rtl/ubt_tri_drive.sv
module ubt_tri_drive #(
    parameter int WIDTH = 18
) (
    input  logic [WIDTH-1:0] data,
    input  logic             drive,
    output logic [WIDTH-1:0] pin_data,
    output logic             pin_en
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pin_data[i] = drive & data[i];
    end
    assign pin_en = drive;

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ab_oe_n,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ab_ce_n,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk,
    input  logic             ba_ce_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_out_en,
    input  logic [WIDTH-1:0] b_line,
    output logic [WIDTH-1:0] b_pull
);

    logic [WIDTH-1:0] ab_word;
    logic             ab_drive;
    logic [WIDTH-1:0] ba_word;
    logic             ba_drive;

    ubt_path #(.WIDTH(WIDTH)) u_ab_path (
        .clk     (clk),
        .rst     (rst),
        .din     (a_in),
        .oe_n    (ab_oe_n),
        .le      (ab_le),
        .edge_in (ab_clk),
        .ce_n    (ab_ce_n),
        .dout    (ab_word),
        .drive   (ab_drive)
    );

    ubt_path #(.WIDTH(WIDTH)) u_ba_path (
        .clk     (clk),
        .rst     (rst),
        .din     (b_line),
        .oe_n    (ba_oe_n),
        .le      (ba_le),
        .edge_in (ba_clk),
        .ce_n    (ba_ce_n),
        .dout    (ba_word),
        .drive   (ba_drive)
    );

    ubt_od_drive #(.WIDTH(WIDTH)) u_b_drv (
        .data     (ab_word),
        .drive    (ab_drive),
        .pull_low (b_pull)
    );

    ubt_tri_drive #(.WIDTH(WIDTH)) u_a_drv (
        .data     (ba_word),
        .drive    (ba_drive),
        .pin_data (a_out),
        .pin_en   (a_out_en)
    );

endmodule

// File: rtl/ubt_xcvr_chk.sv
module ubt_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             ab_oe_n,
    input logic             ba_oe_n,
    input logic             ba_le,
    input logic             ba_ce_n,
    input logic [WIDTH-1:0] a_out,
    input logic             a_out_en,
    input logic [WIDTH-1:0] b_line,
    input logic [WIDTH-1:0] b_pull
);

    // R1
    reset_isolates_chk: assert property (@(posedge clk)
        rst |=> (b_pull == '0 && !a_out_en && a_out == '0));

    // R7
    b_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |=> (b_pull == '0));

    // R7
    a_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        ba_oe_n |=> (!a_out_en && a_out == '0));

    // R2 / R9
    follow_line_chk: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !ba_oe_n) |=> (a_out_en && a_out == $past(b_line)));

    // R5
    gate_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && ba_ce_n && !ba_oe_n && a_out_en) |=> $stable(a_out));

    // R8
    pull_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (b_pull != '0) |-> $past(!ab_oe_n));

endmodule

bind ubt_xcvr ubt_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ab_oe_n  (ab_oe_n),
    .ba_oe_n  (ba_oe_n),
    .ba_le    (ba_le),
    .ba_ce_n  (ba_ce_n),
    .a_out    (a_out),
    .a_out_en (a_out_en),
    .b_line   (b_line),
    .b_pull   (b_pull)
);

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb;

    localparam int W      = 18;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         ab_oe_n, ab_le, ab_clk, ab_ce_n;
    logic         ba_oe_n, ba_le, ba_clk, ba_ce_n;
    logic [W-1:0] a_in, a_out, b_line, b_pull, ext_pull;
    logic         a_out_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    logic [31:0] seed = 32'h1234_5679;

    // reference state
    logic [W-1:0] m_ab, m_ba;
    logic         p_ab, p_ba, e_ab, e_ba;

    always #(CLK_NS/2) clk = ~clk;

    assign b_line = ~b_pull & ~ext_pull;

    ubt_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n),
        .a_in(a_in), .a_out(a_out), .a_out_en(a_out_en),
        .b_line(b_line), .b_pull(b_pull)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    // one system cycle; reference updated from the inputs applied before it
    task automatic tick();
        logic [W-1:0] line_exp;
        line_exp = ~(e_ab ? ~m_ab : '0) & ~ext_pull;
        if (rst) begin
            m_ab = '0; m_ba = '0; p_ab = 1; p_ba = 1; e_ab = 0; e_ba = 0;
        end else begin
            if (ab_le || (!ab_ce_n && ab_clk && !p_ab)) m_ab = a_in;
            if (ba_le || (!ba_ce_n && ba_clk && !p_ba)) m_ba = line_exp;
            p_ab = ab_clk; p_ba = ba_clk;
            e_ab = !ab_oe_n; e_ba = !ba_oe_n;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag);
        logic [W-1:0] xa, xp;
        xa = e_ba ? m_ba : '0;
        xp = e_ab ? ~m_ab : '0;
        checks++;
        if (a_out !== xa || a_out_en !== e_ba || b_pull !== xp) begin
            failures++;
            $display("FAIL %s a_out=%h/%h en=%b/%b b_pull=%h/%h (actual/expected)",
                     tag, a_out, xa, a_out_en, e_ba, b_pull, xp);
        end
    endtask

    function automatic string tag_of(input logic le, ck, ce_n, prev, oe_n);
        if (oe_n) return "R7";
        if (le) return "R2";
        if (ce_n) return "R5";
        if (ck && !prev) return "R3";
        return "R4";
    endfunction

    task automatic rand_inputs();
        seed = nxt(seed); a_in = seed[W-1:0];
        seed = nxt(seed); ext_pull = seed[W-1:0] & nxt(seed)[W-1:0];
        seed = nxt(seed);
        {ab_le, ab_clk, ab_ce_n, ba_le, ba_clk, ba_ce_n} = seed[5:0];
        ab_oe_n = (seed[9:8] == 2'b00);
        ba_oe_n = (seed[11:10] == 2'b00);
    endtask

    initial begin
        rst = 1; ab_oe_n = 1; ba_oe_n = 1;
        ab_le = 0; ba_le = 0; ab_clk = 1; ba_clk = 1; ab_ce_n = 0; ba_ce_n = 0;
        a_in = '1; ext_pull = '0;
        m_ab = '0; m_ba = '0; p_ab = 1; p_ba = 1; e_ab = 0; e_ba = 0;
        @(negedge clk);
        tick(); tick();
        chk("R1 reset");
        // R11: edge input already high leaves word at 0
        rst = 0; ab_oe_n = 0; ba_oe_n = 0;
        tick(); chk("R11 no edge after reset");
        tick(); chk("R11 still held");
        // R6: level enable falls, last followed word stays
        ab_le = 1; a_in = 18'h2A5C3; tick(); chk("R2 follow");
        ab_le = 0; ab_clk = 0; a_in = 18'h15A3C; tick(); chk("R6 after fall");
        tick(); chk("R6 held");
        // R3 capture then R5 inhibit
        ab_clk = 1; tick(); chk("R3 capture");
        ab_clk = 0; a_in = 18'h00FF0; tick();
        ab_ce_n = 1; ab_clk = 1; tick(); chk("R5 gated edge");
        // R9: wired-AND with outside pulls feeds B-to-A
        ab_ce_n = 0; ab_oe_n = 0; ext_pull = 18'h30001; ba_le = 1;
        tick(); tick(); chk("R9 wired-AND receive");
        ba_le = 0; ext_pull = '0; tick(); chk("R9 released hold");
        // sweep: each direction, every prev edge and every control combo
        for (int dir = 0; dir < 2; dir++) begin
            for (int prev = 0; prev < 2; prev++) begin
                for (int c = 0; c < 16; c++) begin
                    logic le, ck, ce, oe;
                    {le, ck, ce, oe} = c[3:0];
                    ab_le = 0; ba_le = 0; ab_ce_n = 1; ba_ce_n = 1;
                    ab_oe_n = 0; ba_oe_n = 0;
                    if (dir == 0) ab_clk = prev[0]; else ba_clk = prev[0];
                    tick(); chk("R4 setup");
                    seed = nxt(seed); a_in = seed[W-1:0];
                    seed = nxt(seed); ext_pull = seed[W-1:0] & 18'h0F0F0;
                    if (dir == 0) begin
                        {ab_le, ab_clk, ab_ce_n, ab_oe_n} = {le, ck, ce, oe};
                        tick(); chk({tag_of(le, ck, ce, prev[0], oe), " A-to-B sweep R10"});
                    end else begin
                        {ba_le, ba_clk, ba_ce_n, ba_oe_n} = {le, ck, ce, oe};
                        tick(); chk({tag_of(le, ck, ce, prev[0], oe), " B-to-A sweep R10"});
                    end
                    ab_oe_n = 0; ba_oe_n = 0;
                    tick(); chk("R8 visible word");
                end
            end
        end
        // long pseudo-random run over all inputs
        for (int n = 0; n < 3000; n++) begin
            rand_inputs();
            tick(); chk("R10 random mix");
        end
        // mid-run reset
        rst = 1; tick(); chk("R1 mid-run reset");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule